// File: doc/BRIEF.md
# Read Data Output Stage with Selectable Latency and Deselect Timing

This block is the last stage on the read side of a synchronous memory. It receives commands as they are presented to the input registers (read, deselect, write), plus the word the array produces in the cycle after a read is captured. From these it produces the word to place on the data bus and a drive-enable that tells the pad ring when to drive that bus.

Two static mode inputs shape the timing. One chooses pipelined operation, where the array word is registered before reaching the bus, or flow-through operation, where the array word reaches the bus in the same cycle it is produced. The other chooses how quickly the bus is released after a deselect: one cycle or two cycles after capture in pipelined mode. Both mode inputs read as low when tied off, which gives pipelined operation with single-cycle release. An output-enable input gates the drive-enable without reference to the clock. The bus is never driven in the cycle after a write is captured.

Top module: `rd_out_stage`

## Requirements
- R1: While reset is asserted and after it is released, `dq_en` is low and `dq_out` is zero until a read reaches the output.
- R2: With `flow_thru` = 0, a read captured at clock edge k drives the array word from cycle k+1 onto `dq_out`, with `dq_en` high, starting after edge k+1. The word stays on the bus until the bus is released.
- R3: With `flow_thru` = 1, a read captured at edge k places `arr_data` on `dq_out` directly during the cycle after edge k, with `dq_en` high. In later idle cycles the last read word is held.
- R4: With `flow_thru` = 0 and `dual_desel` = 0, a deselect captured at edge k, with no read captured at edge k-1, drops `dq_en` right after edge k.
- R5: With `flow_thru` = 0 and `dual_desel` = 1, a deselect captured at edge k keeps the bus driven through cycle k+1 and drops `dq_en` right after edge k+1.
- R6: With `flow_thru` = 1, a deselect captured at edge k drops `dq_en` right after edge k for either `dual_desel` value.
- R7: A deselect captured one edge after a read never removes that read's word: the word is driven for one full cycle, and the bus is released after the next edge.
- R8: `out_en` = 0 forces `dq_en` low at once, with no clock edge needed. Raising it again restores the drive state that was held.
- R9: A write captured at edge k forces `dq_en` low during cycle k+1, including the case where a read captured at edge k-1 would otherwise drive then. The bus stays undriven until a later read.
- R10: With both mode inputs at 0, the block behaves as pipelined with single-cycle deselect.
- R11: For a back-to-back four-read burst, the first word can be sampled at the third edge and each following word at the next edge in pipelined mode (3-1-1-1). In flow-through mode the first word can be sampled at the second edge (2-1-1-1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flow_thru | input | 1 | 1 = flow-through, 0 = pipelined |
| dual_desel | input | 1 | 1 = dual-cycle release, 0 = single-cycle release |
| out_en | input | 1 | Asynchronous output enable, active high |
| cmd_rd | input | 1 | Read command presented to the input registers |
| cmd_desel | input | 1 | Deselect command presented to the input registers |
| cmd_wr | input | 1 | Write command presented to the input registers |
| arr_data | input | DATA_W | Array word, valid in the cycle after a read is captured |
| dq_out | output | DATA_W | Word to place on the data bus |
| dq_en | output | 1 | Bus drive enable |

## Verification
The main function is exercised with four-read bursts in each latency mode, which separates the 3-1-1-1 timing from the 2-1-1-1 timing. A read followed by idle cycles and then a deselect tells single-cycle release from dual-cycle release. A read followed directly by a deselect shows that both release settings give the same timing when a read's word is still in flight. Writes placed right after reads, and while the bus is held, show that write gating overrides drive. Toggling the output enable between edges shows that it acts without the clock.

// File: rtl/rd_out_stage.sv
module rd_out_stage #(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flow_thru,
  input  logic              dual_desel,
  input  logic              out_en,
  input  logic              cmd_rd,
  input  logic              cmd_desel,
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_en
);

  logic              s1_rd, s1_desel, s1_wr;
  logic              live, live_nx;
  logic              pipe_clr, ft_clr;
  logic [DATA_W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_rd    <= 1'b0;
      s1_desel <= 1'b0;
      s1_wr    <= 1'b0;
    end else begin
      s1_rd    <= cmd_rd;
      s1_desel <= cmd_desel;
      s1_wr    <= cmd_wr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hold_q <= '0;
    else if (s1_rd) hold_q <= arr_data;
  end

  // Single-cycle release also honours a deselect that lost to a read one edge earlier.
  assign pipe_clr = s1_wr | s1_desel | (~dual_desel & cmd_desel);
  assign ft_clr   = cmd_desel | cmd_wr;

  always_comb begin
    live_nx = live;
    if (flow_thru) begin
      if (cmd_rd)      live_nx = 1'b1;
      else if (ft_clr) live_nx = 1'b0;
    end else begin
      if (s1_rd)         live_nx = 1'b1;
      else if (pipe_clr) live_nx = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= live_nx;
  end

  assign dq_out = (flow_thru && s1_rd) ? arr_data : hold_q;
  assign dq_en  = out_en & live & ~s1_wr;

  AST_PIPE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    s1_rd |=> (hold_q == $past(arr_data))); // R2

  AST_RD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow_thru && s1_rd) |=> live); // R7

  AST_FT_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_thru && cmd_rd) |=> live); // R3

  AST_SCD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow_thru && !dual_desel && cmd_desel && !s1_rd) |=> !live); // R4

  AST_DCD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow_thru && dual_desel && cmd_desel && live && !s1_rd && !s1_desel && !s1_wr) |=> live); // R5

  AST_DCD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow_thru && s1_desel && !s1_rd) |=> !live); // R5

  AST_FT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_thru && (cmd_desel || cmd_wr) && !cmd_rd) |=> !live); // R6

  AST_WR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow_thru && s1_wr && !s1_rd) |=> !live); // R9

endmodule

// File: tb/rd_out_stage_tb.sv
module rd_out_stage_tb_top;
  localparam int DW = 18;
  localparam int NV = 40;
  localparam int VW = 6 + DW + 1 + DW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flow_thru = 1'b0, dual_desel = 1'b0, out_en = 1'b1;
  logic cmd_rd = 1'b0, cmd_desel = 1'b0, cmd_wr = 1'b0;
  logic [DW-1:0] arr_data = '0;
  logic [DW-1:0] dq_out;
  logic dq_en;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rd_out_stage #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .flow_thru(flow_thru), .dual_desel(dual_desel),
    .out_en(out_en), .cmd_rd(cmd_rd), .cmd_desel(cmd_desel), .cmd_wr(cmd_wr),
    .arr_data(arr_data), .dq_out(dq_out), .dq_en(dq_en)
  );

  function automatic logic [VW-1:0] v(input logic ft, dd, oe, rd, ds, wr,
                                      input logic [DW-1:0] arr, input logic en,
                                      input logic [DW-1:0] dq);
    return {ft, dd, oe, rd, ds, wr, arr, en, dq};
  endfunction

  // modes: ft=flow_thru dd=dual_desel; expected values sampled before the next edge
  localparam logic [VW-1:0] TBL [NV] = '{
    v(0,0,1,0,0,0,18'h0,    0,18'h0),
    v(0,0,1,1,0,0,18'h0,    0,18'h0),
    v(0,0,1,1,0,0,18'h0A1,  0,18'h0),
    v(0,0,1,1,0,0,18'h0A2,  1,18'h0A1),
    v(0,0,1,0,0,0,18'h0A3,  1,18'h0A2),
    v(0,0,1,0,0,0,18'h0,    1,18'h0A3),
    v(0,0,1,0,1,0,18'h0,    1,18'h0A3),
    v(0,0,1,0,0,0,18'h0,    0,18'h0),
    v(0,1,1,1,0,0,18'h0,    0,18'h0),
    v(0,1,1,0,0,0,18'h0B1,  0,18'h0),
    v(0,1,1,0,1,0,18'h0,    1,18'h0B1),
    v(0,1,1,0,0,0,18'h0,    1,18'h0B1),
    v(0,1,1,0,0,0,18'h0,    0,18'h0),
    v(0,0,1,1,0,0,18'h0,    0,18'h0),
    v(0,0,1,0,0,0,18'h0C1,  0,18'h0),
    v(0,0,0,0,0,0,18'h0,    0,18'h0),
    v(0,0,1,0,0,0,18'h0,    1,18'h0C1),
    v(0,0,1,0,0,1,18'h0,    1,18'h0C1),
    v(0,0,1,0,0,0,18'h0,    0,18'h0),
    v(0,0,1,0,0,0,18'h0,    0,18'h0),
    v(0,0,1,1,0,0,18'h0,    0,18'h0),
    v(0,0,1,0,0,1,18'h0D1,  0,18'h0),
    v(0,0,1,0,0,0,18'h0,    0,18'h0),
    v(0,0,1,0,0,0,18'h0,    0,18'h0),
    v(1,0,1,1,0,0,18'h0,    0,18'h0),
    v(1,0,1,1,0,0,18'h0E1,  1,18'h0E1),
    v(1,0,1,0,0,0,18'h0E2,  1,18'h0E2),
    v(1,0,1,0,0,0,18'h3FFFF,1,18'h0E2),
    v(1,0,1,0,1,0,18'h0,    1,18'h0E2),
    v(1,0,1,0,0,0,18'h0,    0,18'h0),
    v(1,1,1,1,0,0,18'h0,    0,18'h0),
    v(1,1,1,0,1,0,18'h0F1,  1,18'h0F1),
    v(1,1,1,0,0,0,18'h0,    0,18'h0),
    v(1,0,1,1,0,0,18'h0,    0,18'h0),
    v(1,0,1,0,0,1,18'h02A,  1,18'h02A),
    v(1,0,1,0,0,0,18'h0,    0,18'h0),
    v(0,0,1,1,0,0,18'h0,    0,18'h0),
    v(0,0,1,0,1,0,18'h1F0,  0,18'h0),
    v(0,0,1,0,0,0,18'h0,    1,18'h1F0),
    v(0,0,1,0,0,0,18'h0,    0,18'h0)
  };

  function automatic string req_of(input int i);
    if (i <= 7)  return "R2/R4/R10/R11";
    if (i <= 12) return "R5";
    if (i <= 16) return "R8";
    if (i <= 23) return "R9";
    if (i <= 29) return "R3/R6/R11";
    if (i <= 32) return "R6";
    if (i <= 35) return "R9";
    return "R7";
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [VW-1:0] e);
    {flow_thru, dual_desel, out_en, cmd_rd, cmd_desel, cmd_wr, arr_data} = e[VW-1 -: 6+DW];
  endtask

  task automatic idle();
    cmd_rd = 1'b0; cmd_desel = 1'b0; cmd_wr = 1'b0; arr_data = '0; out_en = 1'b1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected below 5000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(dq_en == 1'b0, "R1", "en in reset", {17'b0, dq_en}, '0);
    chk(dq_out == '0, "R1", "dq in reset", dq_out, '0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] e;
      logic          xen;
      logic [DW-1:0] xdq;
      e = TBL[i];
      xen = e[DW];
      xdq = e[DW-1:0];
      @(negedge clk);
      drive(e);
      #1;
      chk(dq_en == xen, req_of(i), $sformatf("en step %0d", i), {17'b0, dq_en}, {17'b0, xen});
      if (xen) chk(dq_out == xdq, req_of(i), $sformatf("dq step %0d", i), dq_out, xdq);
    end

    // R8: output enable acts between edges
    @(negedge clk); idle(); cmd_rd = 1'b1;
    @(negedge clk); cmd_rd = 1'b0; arr_data = 18'h155;
    @(negedge clk); arr_data = '0; #0.5;
    chk(dq_en == 1'b1, "R8", "en before oe drop", {17'b0, dq_en}, 18'h1);
    out_en = 1'b0; #0.5;
    chk(dq_en == 1'b0, "R8", "en mid-cycle oe low", {17'b0, dq_en}, 18'h0);
    out_en = 1'b1; #0.5;
    chk(dq_out == 18'h155 && dq_en, "R8", "restore mid-cycle", dq_out, 18'h155);

    // R1: reset while bus is driven
    rst_n = 1'b0; #0.5;
    chk(dq_en == 1'b0, "R1", "en after reset", {17'b0, dq_en}, 18'h0);
    chk(dq_out == '0, "R1", "dq after reset", dq_out, '0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk(dq_en == 1'b0, "R1", "en after release", {17'b0, dq_en}, 18'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule